// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block produces every refresh-related strobe for an asynchronous DRAM with multiplexed addresses. It runs from a system clock, and every timing limit is a parameter counted in clock cycles. After reset it keeps the strobes idle for a power-up wait. It then runs a fixed burst of CAS-before-RAS refresh cycles and raises `initDone`. The burst brings the memory to a usable state.

From then on, a distributed timer raises one refresh request per row interval, which is the refresh period divided by the row count. Requests that cannot be served yet are added to a saturating pending count. A host access engine shares the bus through a request/grant pair. A held grant is never taken away. When the host drops its request, the scheduler runs the pending refresh cycles back to back until the count is empty, and only then grants the bus again. The DRAM steps its own row counter during this refresh style, so the block drives no address.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `rasN`, `casN` and `weN` are high, and `initDone` and `hostGnt` are low.
- R2: For the first PWRUP_CYC clocks after reset is released, `rasN` and `casN` stay high.
- R3: After the power-up wait, exactly INIT_CYC refresh cycles run back to back. `initDone` then rises and never falls until the next reset.
- R4: Every falling edge of `rasN` finds `casN` already low for at least T_CSR clocks. `casN` then stays low for at least T_CHR clocks and returns high while `rasN` is still low. `rasN` never falls while `casN` is high.
- R5: `rasN` stays low for at least T_RAS clocks in each cycle. Between two refresh cycles it stays high for at least max(T_RP, T_RPC, T_RC − T_RAS − T_CSR) clocks, and `casN` stays high over that whole interval.
- R6: `weN` is high on every clock, so no refresh cycle can be taken as a test-mode entry.
- R7: Once `initDone` is high, one refresh request is raised every REF_PERIOD_CYC/ROWS clocks. With the host idle, each request gives exactly one refresh cycle.
- R8: No refresh strobe is active while `hostGnt` is high. Requests raised during a grant are served after the host releases the bus, as consecutive cycles with only the minimum precharge between them.
- R9: The pending count saturates at PEND_MAX. Requests raised while it is full are dropped, so a long hold-off gives at most PEND_MAX catch-up cycles.
- R10: `hostGnt` is high only while `initDone` is high. A request made during a refresh burst is held off until the burst ends. After that the grant stays high as long as `hostReq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hostReq | input | 1 | The host access engine wants the bus, or still holds it |
| hostGnt | output | 1 | The bus is granted to the host access engine |
| initDone | output | 1 | The power-up wait and the initialization burst are complete |
| rasN | output | 1 | Row strobe to the DRAM, active low |
| casN | output | 1 | Column strobe to the DRAM, active low |
| weN | output | 1 | Write enable to the DRAM, active low |

## Verification
The bench watches the strobe pins and measures every CAS setup, CAS hold, RAS low and RAS high interval. A design that drops CAS too late, or lets it rise too early, would give a short interval that the bench reports. So would a design that shortens precharge between back-to-back cycles.

The bench holds the grant across several request intervals. A scheduler that refreshes under a live grant would produce strobes during the hold. One that forgets deferred requests would give too short a catch-up burst. A longer hold pushes the pending count to saturation; a count without a ceiling would give more than PEND_MAX catch-up cycles.

The bench also requests the bus from reset and again in the middle of a burst. A design that grants before initialization is complete, or in the middle of a refresh cycle, is exposed there.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    PH_PWRUP,
    PH_IDLE,
    PH_CSU,
    PH_RLOW,
    PH_PRE
  } phase_e;

  typedef struct packed {
    logic rasLow;
    logic casLow;
    logic weLow;
  } strobe_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/dref_tick_timer.sv
module dref_tick_timer #(
  parameter int TICK_CYC = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TICK_W = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [TICK_W-1:0] LAST = TICK_W'(TICK_CYC - 1);

  logic [TICK_W-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dref_ctrl.sv
module dref_ctrl
  import dref_pkg::*;
#(
  parameter int PWRUP_CYC = 40000,
  parameter int INIT_CYC  = 8,
  parameter int PEND_MAX  = 8,
  parameter int T_CSR     = 2,
  parameter int T_CHR     = 2,
  parameter int T_RAS     = 14,
  parameter int PRE_CYC   = 10
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    hostReq,
  output logic    hostGnt,
  output logic    initDone,
  output strobe_t strb
);
  localparam int CNT_W  = $clog2(max3(PWRUP_CYC, T_RAS, max3(PRE_CYC, T_CSR, 2)) + 1);
  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam int INIT_W = $clog2(INIT_CYC + 1);
  localparam logic [CNT_W-1:0]  LD_CSR   = CNT_W'(T_CSR - 1);
  localparam logic [CNT_W-1:0]  LD_RAS   = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0]  LD_PRE   = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0]  CAS_EDGE = CNT_W'(T_RAS - T_CHR);
  localparam logic [PEND_W-1:0] PEND_TOP = PEND_W'(PEND_MAX);

  phase_e            phase, phaseNxt;
  logic [CNT_W-1:0]  phCnt, phCntNxt;
  logic [PEND_W-1:0] pendCnt, pendNxt;
  logic [INIT_W-1:0] initLeft, initLeftNxt;
  logic              initMode, initModeNxt;
  logic              initDoneNxt, hostGntNxt;
  logic              enterRlow, moreWork, busFree, startRef, pendInc, pendDec;

  assign busFree  = !hostGnt && (phase == PH_IDLE);
  assign startRef = busFree && initDone && (pendCnt != '0);
  assign moreWork = initMode ? (initLeft != '0) : (pendCnt != '0);

  always_comb begin
    phaseNxt    = phase;
    phCntNxt    = (phCnt != '0) ? phCnt - 1'b1 : phCnt;
    initModeNxt = initMode;
    initDoneNxt = initDone;
    enterRlow   = 1'b0;
    case (phase)
      PH_PWRUP: begin
        if (phCnt == '0) begin
          phaseNxt = PH_CSU;
          phCntNxt = LD_CSR;
        end
      end
      PH_IDLE: begin
        phCntNxt = phCnt;
        if (startRef) begin
          phaseNxt = PH_CSU;
          phCntNxt = LD_CSR;
        end
      end
      PH_CSU: begin
        if (phCnt == '0) begin
          phaseNxt  = PH_RLOW;
          phCntNxt  = LD_RAS;
          enterRlow = 1'b1;
        end
      end
      PH_RLOW: begin
        if (phCnt == '0) begin
          phaseNxt = PH_PRE;
          phCntNxt = LD_PRE;
        end
      end
      PH_PRE: begin
        if (phCnt == '0) begin
          if (moreWork) begin
            phaseNxt = PH_CSU;
            phCntNxt = LD_CSR;
          end else begin
            phaseNxt = PH_IDLE;
            if (initMode) begin
              initModeNxt = 1'b0;
              initDoneNxt = 1'b1;
            end
          end
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  // pending bookkeeping: ticks add, each committed refresh row strobe subtracts
  assign pendInc = tick && (pendCnt < PEND_TOP);
  assign pendDec = enterRlow && !initMode;

  always_comb begin
    case ({pendInc, pendDec})
      2'b10:   pendNxt = pendCnt + 1'b1;
      2'b01:   pendNxt = pendCnt - 1'b1;
      default: pendNxt = pendCnt;
    endcase
    initLeftNxt = (enterRlow && initMode) ? initLeft - 1'b1 : initLeft;
  end

  // grant: kept while requested, newly given only on a free bus with nothing owed
  always_comb begin
    if (hostGnt) hostGntNxt = hostReq;
    else         hostGntNxt = busFree && initDone && (pendCnt == '0) && hostReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_PWRUP;
      phCnt    <= CNT_W'(PWRUP_CYC - 1);
      initMode <= 1'b1;
      initLeft <= INIT_W'(INIT_CYC);
      pendCnt  <= '0;
      initDone <= 1'b0;
      hostGnt  <= 1'b0;
    end else begin
      phase    <= phaseNxt;
      phCnt    <= phCntNxt;
      initMode <= initModeNxt;
      initLeft <= initLeftNxt;
      pendCnt  <= pendNxt;
      initDone <= initDoneNxt;
      hostGnt  <= hostGntNxt;
    end
  end

  always_comb begin
    strb.rasLow = (phase == PH_RLOW);
    strb.casLow = (phase == PH_CSU) || ((phase == PH_RLOW) && (phCnt >= CAS_EDGE));
    strb.weLow  = 1'b0;
  end
endmodule

// File: rtl/dref_pins.sv
module dref_pins
  import dref_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strb,
  output logic    rasN,
  output logic    casN,
  output logic    weN
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
    end else begin
      rasN <= ~strb.rasLow;
      casN <= ~strb.casLow;
      weN  <= ~strb.weLow;
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PWRUP_CYC      = 40000,
  parameter int INIT_CYC       = 8,
  parameter int ROWS           = 1024,
  parameter int REF_PERIOD_CYC = 3200000,
  parameter int PEND_MAX       = 8,
  parameter int T_CSR          = 2,
  parameter int T_CHR          = 2,
  parameter int T_RAS          = 14,
  parameter int T_RP           = 10,
  parameter int T_RPC          = 2,
  parameter int T_RC           = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hostReq,
  output logic hostGnt,
  output logic initDone,
  output logic rasN,
  output logic casN,
  output logic weN
);
  localparam int TICK_CYC = REF_PERIOD_CYC / ROWS;
  localparam int PRE_CYC  = dref_pkg::max3(T_RP, T_RPC, T_RC - T_RAS - T_CSR);

  dref_pkg::strobe_t strb;
  logic              tick;

  dref_tick_timer #(.TICK_CYC(TICK_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (initDone),
    .tick (tick)
  );

  dref_ctrl #(
    .PWRUP_CYC(PWRUP_CYC),
    .INIT_CYC (INIT_CYC),
    .PEND_MAX (PEND_MAX),
    .T_CSR    (T_CSR),
    .T_CHR    (T_CHR),
    .T_RAS    (T_RAS),
    .PRE_CYC  (PRE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .hostReq (hostReq),
    .hostGnt (hostGnt),
    .initDone(initDone),
    .strb    (strb)
  );

  dref_pins u_pins (
    .clk  (clk),
    .rst_n(rst_n),
    .strb (strb),
    .rasN (rasN),
    .casN (casN),
    .weN  (weN)
  );
endmodule

// File: rtl/dref_checker.sv
module dref_checker #(
  parameter int PWRUP_CYC = 40000,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 14,
  parameter int PRE_CYC   = 10
) (
  input logic clk,
  input logic rst_n,
  input logic rasN,
  input logic casN,
  input logic hostGnt,
  input logic initDone
);
  int  sinceRst, rasLowCnt, rasHighCnt, casSetCnt;
  logic seenRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sinceRst   <= 0;
      rasLowCnt  <= 0;
      rasHighCnt <= 0;
      casSetCnt  <= 0;
      seenRise   <= 1'b0;
    end else begin
      if (sinceRst < PWRUP_CYC) sinceRst <= sinceRst + 1;
      rasLowCnt  <= rasN ? 0 : rasLowCnt + 1;
      rasHighCnt <= rasN ? rasHighCnt + 1 : 0;
      casSetCnt  <= (rasN && !casN) ? casSetCnt + 1 : 0;
      if (!rasN) seenRise <= 1'b1;
    end
  end

  assert_pwrup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst < PWRUP_CYC) |-> (rasN && casN));

  assert_init_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    initDone |=> initDone);

  assert_cbr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN) |-> (!casN && casSetCnt >= T_CSR));

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rasN) |-> (rasLowCnt >= T_RAS));

  assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rasN) && seenRise) |-> (rasHighCnt >= PRE_CYC));

  assert_no_strobe_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hostGnt |-> (rasN && casN));

  assert_grant_after_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hostGnt |-> initDone);
endmodule

bind dram_refresh_sched dref_checker #(
  .PWRUP_CYC(PWRUP_CYC),
  .T_CSR    (T_CSR),
  .T_RAS    (T_RAS),
  .PRE_CYC  (PRE_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rasN    (rasN),
  .casN    (casN),
  .hostGnt (hostGnt),
  .initDone(initDone)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
  localparam int PWRUP = 50;
  localparam int INITN = 8;
  localparam int ROWSB = 16;
  localparam int TICK  = 300;
  localparam int PERB  = TICK * ROWSB;
  localparam int PMAX  = 8;
  localparam int CSR   = 2;
  localparam int CHR   = 2;
  localparam int RASW  = 14;
  localparam int RP    = 10;
  localparam int RPC   = 2;
  localparam int RC    = 26;
  localparam int PREB  = (RP > RPC) ? ((RP > RC - RASW - CSR) ? RP : RC - RASW - CSR)
                                    : ((RPC > RC - RASW - CSR) ? RPC : RC - RASW - CSR);
  localparam int CYC   = CSR + RASW + PREB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostReq = 1'b0;
  logic hostGnt, initDone, rasN, casN, weN;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .PWRUP_CYC(PWRUP), .INIT_CYC(INITN), .ROWS(ROWSB), .REF_PERIOD_CYC(PERB),
    .PEND_MAX(PMAX), .T_CSR(CSR), .T_CHR(CHR), .T_RAS(RASW), .T_RP(RP),
    .T_RPC(RPC), .T_RC(RC)
  ) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .hostReq(hostReq), .hostGnt(hostGnt),
    .initDone(initDone), .rasN(rasN), .casN(casN), .weN(weN)
  );

  // pin monitor
  int  cyc = 0, firstCas = -1, cbrCnt = 0, badFall = 0, weLow = 0;
  int  conflict = 0, earlyGnt = 0;
  int  setRun = 0, holdRun = 0, lowRun = 0, highRun = 0;
  int  minSet = 1 << 30, minHold = 1 << 30, minLow = 1 << 30, minHigh = 1 << 30;
  bit  prevRas = 1'b1, prevCas = 1'b1, seenRise = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!casN && firstCas < 0) firstCas = cyc;
      if (!weN) weLow++;
      if (hostGnt && (!rasN || !casN)) conflict++;
      if (hostGnt && !initDone) earlyGnt++;
      if (prevRas && !rasN) begin
        if (casN) badFall++;
        else cbrCnt++;
        if (setRun < minSet) minSet = setRun;
        if (seenRise && highRun < minHigh) minHigh = highRun;
      end
      if (!prevRas && rasN) begin
        seenRise = 1'b1;
        if (lowRun < minLow) minLow = lowRun;
      end
      if (!rasN && !prevCas && casN && holdRun < minHold) minHold = holdRun;
      setRun  = (rasN && !casN) ? setRun + 1 : 0;
      holdRun = (!rasN && !casN) ? holdRun + 1 : (rasN ? 0 : holdRun);
      lowRun  = rasN ? 0 : lowRun + 1;
      highRun = rasN ? highRun + 1 : 0;
      prevRas = rasN;
      prevCas = casN;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < PREB + 4) begin
      @(negedge clk);
      q = (rasN && casN) ? q + 1 : 0;
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(rasN && casN && weN, "R1 strobes high in reset", {rasN, casN, weN}, 7);
    chk(!initDone && !hostGnt, "R1 flags low in reset", {initDone, hostGnt}, 0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic test_init();
    int n = 0;
    hostReq = 1'b1;
    while (!initDone && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(firstCas >= PWRUP && firstCas <= PWRUP + 2, "R2 power-up wait", firstCas, PWRUP + 1);
    chk(cbrCnt == INITN, "R3 init burst length", cbrCnt, INITN);
    chk(earlyGnt == 0, "R10 no grant before init", earlyGnt, 0);
    repeat (3) @(negedge clk);
    chk(hostGnt == 1'b1, "R10 grant after init", hostGnt, 1);
    @(negedge clk) hostReq = 1'b0;
    wait_quiet();
  endtask

  task automatic test_periodic();
    int base;
    wait_quiet();
    base = cbrCnt;
    repeat (10 * TICK) @(negedge clk);
    chk(cbrCnt - base >= 9 && cbrCnt - base <= 11, "R7 one refresh per interval", cbrCnt - base, 10);
  endtask

  task automatic hold_and_release(input int holdTicks, output int during, output int after);
    int base;
    wait_quiet();
    @(negedge clk) hostReq = 1'b1;
    while (!hostGnt) @(negedge clk);
    base = cbrCnt;
    repeat (holdTicks * TICK + 10) @(negedge clk);
    during = cbrCnt - base;
    hostReq = 1'b0;
    base = cbrCnt;
    repeat (PMAX * CYC + 20) @(negedge clk);
    after = cbrCnt - base;
  endtask

  task automatic test_holdoff();
    int d, a;
    hold_and_release(5, d, a);
    chk(d == 0, "R8 no refresh under grant", d, 0);
    chk(a >= 5 && a <= 7, "R8 deferred burst", a, 5);
  endtask

  task automatic test_saturate();
    int d, a;
    hold_and_release(12, d, a);
    chk(d == 0, "R8 no refresh under long grant", d, 0);
    chk(a >= PMAX && a <= PMAX + 1, "R9 pending saturates", a, PMAX);
  endtask

  task automatic test_req_in_burst();
    int d, a, n = 0;
    bit blocked = 1'b1;
    wait_quiet();
    @(negedge clk) hostReq = 1'b1;
    while (!hostGnt) @(negedge clk);
    repeat (3 * TICK + 10) @(negedge clk);
    hostReq = 1'b0;
    while (rasN && n < 200) begin @(negedge clk); n++; end
    hostReq = 1'b1;
    repeat (2 * CYC) begin
      @(negedge clk);
      if (hostGnt) blocked = 1'b0;
    end
    chk(blocked, "R10 request held off during burst", !blocked, 0);
    n = 0;
    while (!hostGnt && n < 2000) begin @(negedge clk); n++; end
    chk(hostGnt && rasN && casN, "R10 grant after burst", hostGnt, 1);
    repeat (50) @(negedge clk);
    chk(hostGnt == 1'b1, "R10 grant held while requested", hostGnt, 1);
    hostReq = 1'b0;
    d = 0; a = 0;
  endtask

  task automatic test_timing();
    chk(minSet >= CSR, "R4 CAS setup before RAS", minSet, CSR);
    chk(minHold >= CHR, "R4 CAS hold after RAS", minHold, CHR);
    chk(badFall == 0, "R4 RAS fell with CAS high", badFall, 0);
    chk(minLow >= RASW, "R5 RAS low width", minLow, RASW);
    chk(minHigh >= PREB, "R5 RAS precharge", minHigh, PREB);
    chk(weLow == 0, "R6 WE held high", weLow, 0);
    chk(conflict == 0, "R8 strobes during grant", conflict, 0);
    chk(initDone == 1'b1, "R3 init stays done", initDone, 1);
  endtask

  initial begin
    test_reset();
    test_init();
    test_periodic();
    test_holdoff();
    test_saturate();
    test_req_in_burst();
    wait_quiet();
    test_timing();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule